// File: doc/BRIEF.md
# Hardware Trigger Synchronizer and Veto Gate

This block brings an asynchronous external trigger line into the system clock domain and decides which of its pulses go on to the downstream logic. The line is sampled by a single flip-flop and then edge-detected. A held-high level therefore yields one candidate only. A veto stage then accepts or drops each candidate.

A candidate is accepted only when three conditions hold. Fewer triggers have been accepted since the last host clear than the programmed allowance. The host has not locked out the hardware input. At least three clock cycles have passed since the previous accepted hardware trigger. Software triggers do not go through the veto. They are merged with the accepted hardware triggers into one registered output, which pulses for one cycle.

A host writes commands through a strobe, a 2-bit selector and a 3-bit data field. The commands set the allowance, clear the accepted count, and lock or unlock the hardware input. Status outputs show whether the veto is closed and how many hardware triggers have been accepted.

Top module: `trig_veto_gate`

## Requirements
- R1: `hw_trig_i` is sampled on each rising clock edge. When it is first sampled high at edge E0 and the veto is open, `trig_o` is high for one cycle starting at edge E0+1.
- R2: A level held high on `hw_trig_i` for several cycles gives exactly one pulse. A further pulse requires at least one low sample first.
- R3: Out of reset the allowance field is 0, which permits one hardware trigger. Once the accepted count equals the allowance plus one, `veto_closed_o` is 1 and further hardware triggers give no pulse and do not change the count.
- R4: A host write with `host_sel_i`=0 stores `host_data_i` as the allowance field. A value of n permits n+1 triggers, and the same write zeroes the accepted count.
- R5: A host write with `host_sel_i`=1 zeroes the accepted count, which reopens the veto unless the lockout is set.
- R6: A host write with `host_sel_i`=2 sets the lockout to `host_data_i[0]`. While the lockout is 1, `veto_closed_o` is 1, hardware triggers give no pulse, and the count is unchanged.
- R7: A hardware candidate that arrives one or two cycles after an accepted hardware trigger is dropped and is not counted.
- R8: A high `sw_trig_i` at an edge makes `trig_o` high in the following cycle, whatever the veto state, and does not change the count.
- R9: When a software trigger and an accepted hardware trigger fall on the same output cycle, `trig_o` is high for that one cycle only, and the hardware trigger is still counted.
- R10: `accept_cnt_o` equals the number of hardware triggers accepted since the last reset, clear or allowance write.
- R11: A host write with `host_sel_i`=3 has no effect on the count, the allowance or the lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_trig_i | input | 1 | Asynchronous external trigger line |
| sw_trig_i | input | 1 | Synchronous software trigger, bypasses the veto |
| host_we_i | input | 1 | Host command strobe |
| host_sel_i | input | 2 | Command select: 0 allowance, 1 clear, 2 lockout, 3 none |
| host_data_i | input | 3 | Command data |
| trig_o | output | 1 | Merged one-cycle trigger pulse |
| veto_closed_o | output | 1 | Veto currently blocks hardware triggers |
| accept_cnt_o | output | 4 | Hardware triggers accepted since last clear |

## Verification
A software trigger and an accepted hardware trigger can both target the same output cycle. The bench provokes this by driving `sw_trig_i` one cycle after `hw_trig_i`, so that both arrive at the output register together. The scoreboard expects a single pulse in that cycle and a low output in the next. A status check then confirms that the hardware trigger was counted. A host clear that lands in the same cycle as an accepted trigger is the other overlap, and the clear wins the count.

// File: rtl/trig_veto_pkg.sv
package trig_veto_pkg;
  typedef enum logic [1:0] {
    CMD_LIMIT   = 2'd0,
    CMD_CLEAR   = 2'd1,
    CMD_LOCK    = 2'd2,
    CMD_NONE    = 2'd3
  } host_cmd_e;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic cand_o
);
  logic smp_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= async_i;
      prev_q <= smp_q;
    end
  end

  assign cand_o = smp_q & ~prev_q;

  p_one_cand_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_o |=> !cand_o);
endmodule

// File: rtl/trig_veto_core.sv
module trig_veto_core
  import trig_veto_pkg::*;
#(
  parameter int CNT_W   = 3,
  parameter int GAP_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cand_i,
  input  logic             host_we_i,
  input  logic [1:0]       host_sel_i,
  input  logic [CNT_W-1:0] host_data_i,
  output logic             acc_o,
  output logic             closed_o,
  output logic [CNT_W:0]   cnt_o
);
  localparam int GAP_W = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;

  logic [CNT_W-1:0] limit_q;
  logic [CNT_W:0]   cnt_q;
  logic [CNT_W:0]   allowed;
  logic [GAP_W-1:0] gap_q;
  logic             lock_q;
  logic             zero_cnt;

  assign allowed  = {1'b0, limit_q} + {{CNT_W{1'b0}}, 1'b1};
  assign closed_o = lock_q | (cnt_q >= allowed);
  assign acc_o    = cand_i & ~closed_o & (gap_q == '0);
  assign zero_cnt = host_we_i &&
                    (host_sel_i == CMD_LIMIT || host_sel_i == CMD_CLEAR);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      lock_q  <= 1'b0;
    end else if (host_we_i) begin
      if (host_sel_i == CMD_LIMIT) limit_q <= host_data_i;
      if (host_sel_i == CMD_LOCK)  lock_q  <= host_data_i[0];
    end
  end

  // host clear outranks a same-cycle accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (zero_cnt) cnt_q <= '0;
    else if (acc_o)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           gap_q <= '0;
    else if (acc_o)        gap_q <= GAP_W'(GAP_CYC - 1);
    else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= allowed);
  p_lock_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> !acc_o);
  p_spacing_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !acc_o);

  generate
    if (GAP_CYC >= 3) begin : g_gap2
      p_spacing2_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_o |=> ##1 !acc_o);
    end
  endgenerate
endmodule

// File: rtl/trig_veto_gate.sv
module trig_veto_gate #(
  parameter int CNT_W   = 3,
  parameter int GAP_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_trig_i,
  input  logic             sw_trig_i,
  input  logic             host_we_i,
  input  logic [1:0]       host_sel_i,
  input  logic [CNT_W-1:0] host_data_i,
  output logic             trig_o,
  output logic             veto_closed_o,
  output logic [CNT_W:0]   accept_cnt_o
);
  logic cand, hw_acc, trig_q;

  trig_edge_sync i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (hw_trig_i),
    .cand_o  (cand)
  );

  trig_veto_core #(.CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cand_i      (cand),
    .host_we_i   (host_we_i),
    .host_sel_i  (host_sel_i),
    .host_data_i (host_data_i),
    .acc_o       (hw_acc),
    .closed_o    (veto_closed_o),
    .cnt_o       (accept_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= hw_acc | sw_trig_i;
  end

  assign trig_o = trig_q;

  p_hw_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_acc |=> trig_o);
  p_sw_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_trig_i |=> trig_o);
endmodule

// File: tb/test_trig_veto_gate.sv
module test_trig_veto_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_trig_i = 1'b0;
  logic       sw_trig_i = 1'b0;
  logic       host_we_i = 1'b0;
  logic [1:0] host_sel_i = 2'd3;
  logic [2:0] host_data_i = 3'd0;
  logic       trig_o, veto_closed_o;
  logic [3:0] accept_cnt_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  trig_veto_gate i_trig_veto_gate (
    .clk_i, .rst_ni, .hw_trig_i, .sw_trig_i, .host_we_i,
    .host_sel_i, .host_data_i, .trig_o, .veto_closed_o, .accept_cnt_o
  );

  function automatic void expect_at(int c);
    if (exp_q.size() == 0 || exp_q[$] != c) exp_q.push_back(c);
  endfunction

  // monitor: compare trig_o against scoreboard every cycle
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit want;
      want = (exp_q.size() > 0 && exp_q[0] == cyc);
      if (want || trig_o) begin
        checks++;
        if (trig_o !== want) begin
          errors++;
          $display("FAIL R1/R9 trig_o at cycle %0d: actual %0b expected %0b", cyc, trig_o, want);
        end
      end
      if (want) void'(exp_q.pop_front());
    end
  end

  task automatic hw_pulse(bit acc);
    @(negedge clk_i);
    hw_trig_i = 1'b1;
    if (acc) expect_at(cyc + 2);
    @(negedge clk_i);
    hw_trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic sw_pulse();
    @(negedge clk_i);
    sw_trig_i = 1'b1;
    expect_at(cyc + 1);
    @(negedge clk_i);
    sw_trig_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic host(input logic [1:0] sel, input logic [2:0] data);
    @(negedge clk_i);
    host_we_i = 1'b1; host_sel_i = sel; host_data_i = data;
    @(negedge clk_i);
    host_we_i = 1'b0; host_sel_i = 2'd3;
    @(negedge clk_i);
  endtask

  task automatic check_stat(string req, int cnt, bit closed);
    @(negedge clk_i);
    checks++;
    if (accept_cnt_o !== 4'(cnt) || veto_closed_o !== closed) begin
      errors++;
      $display("FAIL %s status: actual cnt %0d closed %0b expected cnt %0d closed %0b",
               req, accept_cnt_o, veto_closed_o, cnt, closed);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state (R3)
    checks++;
    if (trig_o !== 1'b0) begin errors++; $display("FAIL R3 reset trig_o: actual %0b expected 0", trig_o); end
    check_stat("R3", 0, 0);
    // R1: first trigger accepted, then R3 closes after one
    hw_pulse(1);
    check_stat("R3", 1, 1);
    hw_pulse(0);
    check_stat("R3", 1, 1);
    // R5 clear
    host(2'd1, 3'd0);
    check_stat("R5", 0, 0);
    // R4: allowance 2 -> three triggers
    hw_pulse(1);
    host(2'd0, 3'd2);
    check_stat("R4", 0, 0);
    hw_pulse(1); hw_pulse(1); hw_pulse(1); hw_pulse(0);
    check_stat("R10", 3, 1);
    // R2: long level gives one pulse
    host(2'd1, 3'd0);
    @(negedge clk_i);
    hw_trig_i = 1'b1; expect_at(cyc + 2);
    repeat (6) @(negedge clk_i);
    hw_trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_stat("R2", 1, 0);
    // R7: 1-0-1-0-1, middle candidate dropped
    @(negedge clk_i); hw_trig_i = 1'b1; expect_at(cyc + 2);
    @(negedge clk_i); hw_trig_i = 1'b0;
    @(negedge clk_i); hw_trig_i = 1'b1;
    @(negedge clk_i); hw_trig_i = 1'b0;
    @(negedge clk_i); hw_trig_i = 1'b1; expect_at(cyc + 2);
    @(negedge clk_i); hw_trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_stat("R7", 3, 1);
    host(2'd1, 3'd0);
    // R6 lockout, R8 software bypass
    host(2'd2, 3'd1);
    check_stat("R6", 0, 1);
    hw_pulse(0);
    sw_pulse();
    check_stat("R8", 0, 1);
    host(2'd2, 3'd0);
    check_stat("R6", 0, 0);
    // R11 no-op command
    hw_pulse(1);
    host(2'd3, 3'd7);
    check_stat("R11", 1, 0);
    // R9 coincident software and hardware
    @(negedge clk_i); hw_trig_i = 1'b1; expect_at(cyc + 2);
    @(negedge clk_i); hw_trig_i = 1'b0; sw_trig_i = 1'b1; expect_at(cyc + 1);
    @(negedge clk_i); sw_trig_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_stat("R9", 2, 0);
    repeat (3) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing pulses: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule